// File: doc/BRIEF.md
# Dual-Width Integer ALU

This block is the integer execution unit of a register machine with 64-bit general registers. Each accepted request carries a destination operand, a source operand (either a register value or a signed 32-bit immediate), an operation code, a size code and a width flag. The block returns the new destination value. The destination works as an accumulator, so the result is `dst op src`. Every operation exists in a 64-bit form and a 32-bit form.

The operations are add, subtract, multiply, unsigned divide and remainder, and, or, xor, three shifts, negate and move. There are also moves that sign-extend 8, 16 or 32 bits, conversions to little-endian or big-endian order, and byte reversal at 8, 16, 32 or 64 bits. Most operations finish in one cycle. Divide and remainder use an iterative radix-2 unit. While that unit runs, `in_ready` is low. Results come back on `out_valid` in the order the requests were accepted.

Top module: `dual_width_alu`

## Requirements
- R1: While reset is held, and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: A request that is not a divide or remainder is accepted on a clock edge where `in_valid` and `in_ready` are both 1. Its result appears with `out_valid` high for exactly one cycle, directly after that edge.
- R3: With `in_use_imm`=1, the source operand is `in_imm` sign-extended to 64 bits before any operation. With `in_use_imm`=0, the source operand is `in_src`.
- R4: Op codes: 0 add, 1 sub, 2 mul (low 64 bits), 5 and, 6 or, 7 xor, 11 negate (the two's complement of dst; src is ignored), 12 move (src).
- R5: With `in_w32`=1, ops 0-13 use only the low 32 bits of dst and src. Their result is zero-extended into bits 63:32.
- R6: Op 8 is logical left shift, op 9 is logical right shift and op 10 is arithmetic right shift. The shift amount is src masked to 6 bits in 64-bit mode and to 5 bits in 32-bit mode. An arithmetic shift copies bit 63, or bit 31 in 32-bit mode.
- R7: Op 13 sign-extends the low part of src, chosen by `in_size` (0=8, 1=16, 2=32, 3=64 bits), to 64 bits. In 32-bit mode it sign-extends to 32 bits and zero-fills above. Size 3 is a plain move.
- R8: Op 3 (unsigned quotient) and op 4 (unsigned remainder) drop `in_ready` in the cycle after acceptance. They keep it low until the result is delivered. The 32-bit forms divide the low 32 bits.
- R9: A zero divisor gives quotient 0. The remainder by zero returns dst unchanged; in 32-bit mode this is the low 32 bits of dst, zero-extended.
- R10: Op 14 converts to little-endian and op 15 converts to big-endian, at the size given by `in_size` (0=8, 1=16, 2=32, 3=64 bits). The width flag is ignored. If the target order matches the host order (parameter `HOST_LE`, default 1 = little), the low bits of that size are kept and the rest are zeroed. Otherwise the bytes within that size are reversed and the bits above it are zeroed.
- R11: Op 16 reverses the bytes within the size given by `in_size` and zeroes the bits above it, whatever the host order.
- R12: `in_valid` while `in_ready` is low is ignored: no result is produced for it, and `out_valid` stays low while `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_op | input | 5 | Operation code |
| in_w32 | input | 1 | 1 = 32-bit form |
| in_size | input | 2 | Size code for sign-extend, endian and byte-reverse ops |
| in_use_imm | input | 1 | Select immediate as source |
| in_dst | input | 64 | Destination operand |
| in_src | input | 64 | Source register operand |
| in_imm | input | 32 | Signed immediate |
| out_valid | output | 1 | Result valid for one cycle |
| out_result | output | 64 | New destination value |

## Verification
The assertions check on every cycle the properties that hold in general: the one-cycle result timing of single-cycle ops, `in_ready` dropping after a divide is accepted, silence on the output while busy, zero upper bits for 32-bit results, and that the divider is never restarted while it runs. The operation values themselves can only be shown by the bench's scenarios. These include shift-amount masking, sign extension from each size, byte order at each size, unsigned division of values with the top bit set, and both divide-by-zero rules. The bench also shows that a request presented while busy is dropped.

// File: rtl/dwalu_pkg.sv
package dwalu_pkg;

    localparam int XLEN   = 64;
    localparam int HLEN   = 32;
    localparam int OP_W   = 5;
    localparam int BYTE_W = 8;
    localparam int NSIZE  = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 5'd0,
        OP_SUB   = 5'd1,
        OP_MUL   = 5'd2,
        OP_DIV   = 5'd3,
        OP_MOD   = 5'd4,
        OP_AND   = 5'd5,
        OP_OR    = 5'd6,
        OP_XOR   = 5'd7,
        OP_SHL   = 5'd8,
        OP_SHR   = 5'd9,
        OP_SAR   = 5'd10,
        OP_NEG   = 5'd11,
        OP_MOV   = 5'd12,
        OP_MOVSX = 5'd13,
        OP_TOLE  = 5'd14,
        OP_TOBE  = 5'd15,
        OP_BREV  = 5'd16
    } op_e;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } size_e;

    typedef struct packed {
        op_e             op;
        logic            w32;
        size_e           sz;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
    } req_t;

    function automatic logic is_div_op(op_e o);
        return (o == OP_DIV) || (o == OP_MOD);
    endfunction

    function automatic logic is_byte_op(op_e o);
        return (o == OP_TOLE) || (o == OP_TOBE) || (o == OP_BREV);
    endfunction

    function automatic logic [XLEN-1:0] sext_imm(logic [HLEN-1:0] i);
        return {{(XLEN-HLEN){i[HLEN-1]}}, i};
    endfunction

    function automatic logic [XLEN-1:0] zext_low(logic [XLEN-1:0] v);
        return {{(XLEN-HLEN){1'b0}}, v[HLEN-1:0]};
    endfunction

endpackage

// File: rtl/dwalu_fast.sv
module dwalu_fast
    import dwalu_pkg::*;
(
    input  req_t            req,
    output logic [XLEN-1:0] y
);
    localparam int SH64 = $clog2(XLEN);
    localparam int SH32 = $clog2(HLEN);

    logic [XLEN-1:0]        r64;
    logic [HLEN-1:0]        r32;
    logic [HLEN-1:0]        a32, b32;
    logic signed [XLEN-1:0] a64s;
    logic signed [HLEN-1:0] a32s;
    logic [SH64-1:0]        amt64;
    logic [SH32-1:0]        amt32;

    assign a32   = req.a[HLEN-1:0];
    assign b32   = req.b[HLEN-1:0];
    assign a64s  = req.a;
    assign a32s  = a32;
    assign amt64 = req.b[SH64-1:0];
    assign amt32 = req.b[SH32-1:0];

    always_comb begin
        r64 = '0;
        r32 = '0;
        unique case (req.op)
            OP_ADD: begin r64 = req.a + req.b;  r32 = a32 + b32; end
            OP_SUB: begin r64 = req.a - req.b;  r32 = a32 - b32; end
            OP_MUL: begin r64 = req.a * req.b;  r32 = a32 * b32; end
            OP_AND: begin r64 = req.a & req.b;  r32 = a32 & b32; end
            OP_OR:  begin r64 = req.a | req.b;  r32 = a32 | b32; end
            OP_XOR: begin r64 = req.a ^ req.b;  r32 = a32 ^ b32; end
            OP_SHL: begin r64 = req.a << amt64; r32 = a32 << amt32; end
            OP_SHR: begin r64 = req.a >> amt64; r32 = a32 >> amt32; end
            OP_SAR: begin
                r64 = $unsigned(a64s >>> amt64);
                r32 = $unsigned(a32s >>> amt32);
            end
            OP_NEG: begin r64 = -req.a; r32 = -a32; end
            OP_MOV: begin r64 = req.b;  r32 = b32; end
            OP_MOVSX: begin
                case (req.sz)
                    SZ_8: begin
                        r64 = {{(XLEN-8){req.b[7]}}, req.b[7:0]};
                        r32 = {{(HLEN-8){req.b[7]}}, req.b[7:0]};
                    end
                    SZ_16: begin
                        r64 = {{(XLEN-16){req.b[15]}}, req.b[15:0]};
                        r32 = {{(HLEN-16){req.b[15]}}, req.b[15:0]};
                    end
                    SZ_32: begin
                        r64 = {{(XLEN-HLEN){req.b[HLEN-1]}}, b32};
                        r32 = b32;
                    end
                    default: begin
                        r64 = req.b;
                        r32 = b32;
                    end
                endcase
            end
            default: begin r64 = '0; r32 = '0; end
        endcase
        y = req.w32 ? {{(XLEN-HLEN){1'b0}}, r32} : r64;
    end

endmodule

// File: rtl/dwalu_bytes.sv
module dwalu_bytes
    import dwalu_pkg::*;
#(
    parameter bit HOST_LE = 1'b1
) (
    input  op_e             op,
    input  size_e           sz,
    input  logic [XLEN-1:0] val,
    output logic [XLEN-1:0] y
);
    localparam int NBYTES = XLEN / BYTE_W;

    logic [NSIZE-1:0][XLEN-1:0] rev_w;
    logic [NSIZE-1:0][XLEN-1:0] keep_w;
    logic                       swap;

    for (genvar g = 0; g < NSIZE; g++) begin : g_size
        localparam int N = 1 << g;
        for (genvar i = 0; i < NBYTES; i++) begin : g_lane
            if (i < N) begin : g_in
                assign rev_w[g][BYTE_W*i +: BYTE_W]  = val[BYTE_W*(N-1-i) +: BYTE_W];
                assign keep_w[g][BYTE_W*i +: BYTE_W] = val[BYTE_W*i +: BYTE_W];
            end else begin : g_out
                assign rev_w[g][BYTE_W*i +: BYTE_W]  = '0;
                assign keep_w[g][BYTE_W*i +: BYTE_W] = '0;
            end
        end
    end

    always_comb begin
        case (op)
            OP_TOLE: swap = !HOST_LE;
            OP_TOBE: swap = HOST_LE;
            default: swap = 1'b1;
        endcase
        y = swap ? rev_w[sz] : keep_w[sz];
    end

endmodule

// File: rtl/dwalu_div.sv
module dwalu_div #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W + 1);

    logic          busy;
    logic [CW-1:0] cnt;
    logic [W-1:0]  q_r, r_r, d_r;
    logic [W:0]    trial, diff;

    assign trial = {r_r, q_r[W-1]};
    assign diff  = trial - {1'b0, d_r};
    assign quot  = q_r;
    assign rem   = r_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
            q_r  <= '0;
            r_r  <= '0;
            d_r  <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                q_r  <= dividend;
                r_r  <= '0;
                d_r  <= divisor;
                cnt  <= CW'(W);
                busy <= 1'b1;
            end else if (busy) begin
                if (diff[W]) begin
                    r_r <= trial[W-1:0];
                    q_r <= {q_r[W-2:0], 1'b0};
                end else begin
                    r_r <= diff[W-1:0];
                    q_r <= {q_r[W-2:0], 1'b1};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R8: the controller never restarts a running division
    assert_start_idle_R8: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    // R8: completion is a single-cycle pulse
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/dual_width_alu.sv
module dual_width_alu
    import dwalu_pkg::*;
#(
    parameter bit HOST_LE = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [OP_W-1:0] in_op,
    input  logic            in_w32,
    input  logic [1:0]      in_size,
    input  logic            in_use_imm,
    input  logic [XLEN-1:0] in_dst,
    input  logic [XLEN-1:0] in_src,
    input  logic [HLEN-1:0] in_imm,
    output logic            out_valid,
    output logic [XLEN-1:0] out_result
);
    typedef enum logic {ST_IDLE, ST_DIV} state_e;

    state_e          state;
    req_t            req;
    logic            accept;
    logic [XLEN-1:0] fast_y, byte_y, single_y;
    logic [XLEN-1:0] dvd, dvs;
    logic            div_start, div_done;
    logic [XLEN-1:0] div_q, div_r, div_pick;
    logic            mod_q, zero_q;
    logic [XLEN-1:0] keep_q;
    logic [XLEN-1:0] res_q;
    logic            vld_q;

    assign req.op  = op_e'(in_op);
    assign req.w32 = in_w32;
    assign req.sz  = size_e'(in_size);
    assign req.a   = in_dst;
    assign req.b   = in_use_imm ? sext_imm(in_imm) : in_src;

    assign in_ready   = (state == ST_IDLE);
    assign accept     = in_valid && in_ready;
    assign out_valid  = vld_q;
    assign out_result = res_q;

    dwalu_fast u_fast (
        .req (req),
        .y   (fast_y)
    );

    dwalu_bytes #(.HOST_LE(HOST_LE)) u_bytes (
        .op  (req.op),
        .sz  (req.sz),
        .val (req.a),
        .y   (byte_y)
    );

    assign single_y  = is_byte_op(req.op) ? byte_y : fast_y;
    assign dvd       = req.w32 ? zext_low(req.a) : req.a;
    assign dvs       = req.w32 ? zext_low(req.b) : req.b;
    assign div_start = accept && is_div_op(req.op);

    dwalu_div #(.W(XLEN)) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (div_start),
        .dividend (dvd),
        .divisor  (dvs),
        .done     (div_done),
        .quot     (div_q),
        .rem      (div_r)
    );

    always_comb begin
        if (zero_q) div_pick = mod_q ? keep_q : '0;
        else        div_pick = mod_q ? div_r : div_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            vld_q  <= 1'b0;
            res_q  <= '0;
            mod_q  <= 1'b0;
            zero_q <= 1'b0;
            keep_q <= '0;
        end else begin
            vld_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (is_div_op(req.op)) begin
                            state  <= ST_DIV;
                            mod_q  <= (req.op == OP_MOD);
                            zero_q <= (dvs == '0);
                            keep_q <= dvd;
                        end else begin
                            res_q <= single_y;
                            vld_q <= 1'b1;
                        end
                    end
                end
                default: begin
                    if (div_done) begin
                        res_q <= div_pick;
                        vld_q <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    // R1: idle and silent right after reset
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready));

    // R2: single-cycle ops answer on the next cycle
    assert_fast_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (accept && !is_div_op(req.op)) |=> out_valid);

    // R8: a divide request makes the block busy
    assert_div_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (accept && is_div_op(req.op)) |=> !in_ready);

    // R12: no result leaves while the block is busy
    assert_busy_silent_R12: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> !out_valid);

    // R5: 32-bit forms leave the upper half zero
    assert_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (accept && req.w32 && !is_div_op(req.op) && !is_byte_op(req.op))
        |=> (out_result[XLEN-1:HLEN] == '0));

endmodule

// File: tb/dual_width_alu_tb.sv
module dual_width_alu_tb;

    localparam int CLK_PERIOD = 10;

    localparam logic [4:0] ADD = 5'd0,  SUB = 5'd1,  MUL = 5'd2,  DIV = 5'd3,
                           MOD = 5'd4,  AND = 5'd5,  OR_ = 5'd6,  XOR = 5'd7,
                           SHL = 5'd8,  SHR = 5'd9,  SAR = 5'd10, NEG = 5'd11,
                           MOV = 5'd12, MSX = 5'd13, TLE = 5'd14, TBE = 5'd15,
                           BRV = 5'd16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [4:0]  in_op = '0;
    logic        in_w32 = 1'b0;
    logic [1:0]  in_size = '0;
    logic        in_use_imm = 1'b0;
    logic [63:0] in_dst = '0;
    logic [63:0] in_src = '0;
    logic [31:0] in_imm = '0;
    logic        out_valid;
    logic [63:0] out_result;

    int          n_checks = 0;
    int          n_fail   = 0;
    bit          finished = 1'b0;
    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_width_alu u_dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_op      (in_op),
        .in_w32     (in_w32),
        .in_size    (in_size),
        .in_use_imm (in_use_imm),
        .in_dst     (in_dst),
        .in_src     (in_src),
        .in_imm     (in_imm),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    task automatic send(input logic [4:0] op, input logic w32, input logic [1:0] sz,
                        input logic ui, input logic [63:0] d, input logic [63:0] s,
                        input logic [31:0] im, input logic [63:0] e, input string tag);
        while (!in_ready) @(negedge clk);
        in_op = op; in_w32 = w32; in_size = sz; in_use_imm = ui;
        in_dst = d; in_src = s; in_imm = im;
        in_valid = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor: pops the scoreboard whenever a result appears
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R12: unexpected result actual=%h expected=none", out_result);
            end else begin
                logic [63:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (out_result !== e) begin
                    n_fail++;
                    $display("FAIL %s: actual=%h expected=%h", t, out_result, e);
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            n_fail++;
            $display("FAIL R1: actual valid=%b ready=%b expected valid=0 ready=1", out_valid, in_ready);
        end

        // R4 / R5 add at both widths
        send(ADD, 0, 0, 0, 64'h0000_0001_FFFF_FFFF, 64'h1, 0, 64'h0000_0002_0000_0000, "R4 add64");
        send(ADD, 1, 0, 0, 64'h0000_0001_FFFF_FFFF, 64'h1, 0, 64'h0, "R5 add32");
        // R3 immediate sign extension
        send(SUB, 0, 0, 1, 64'h5, 64'h0, 32'hFFFF_FFFF, 64'h6, "R3 sub imm");
        send(MOV, 0, 0, 1, 64'h0, 64'h0, 32'h8000_0000, 64'hFFFF_FFFF_8000_0000, "R3 mov imm");
        send(MOV, 1, 0, 1, 64'h0, 64'h0, 32'h8000_0000, 64'h0000_0000_8000_0000, "R5 mov32 imm");
        // R4 / R5 mul, logic ops, negate
        send(MUL, 0, 0, 0, 64'h1_0000_0000, 64'h3, 0, 64'h3_0000_0000, "R4 mul64");
        send(MUL, 1, 0, 0, 64'h1_0000_0000, 64'h3, 0, 64'h0, "R5 mul32");
        send(AND, 0, 0, 0, 64'hF0F0, 64'h0FF0, 0, 64'h00F0, "R4 and");
        send(OR_, 0, 0, 0, 64'hF0F0, 64'h0FF0, 0, 64'hFFF0, "R4 or");
        send(XOR, 0, 0, 0, 64'hF0F0, 64'h0FF0, 0, 64'hFF00, "R4 xor");
        send(NEG, 0, 0, 0, 64'h1, 64'h55, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R4 neg64");
        send(NEG, 1, 0, 0, 64'h1, 64'h55, 0, 64'h0000_0000_FFFF_FFFF, "R5 neg32");
        // R6 shifts with amount masking
        send(SHL, 0, 0, 0, 64'h1, 64'd65, 0, 64'h2, "R6 shl64 mask");
        send(SHL, 1, 0, 0, 64'h1, 64'd33, 0, 64'h2, "R6 shl32 mask");
        send(SHR, 0, 0, 0, 64'h8000_0000_0000_0000, 64'd63, 0, 64'h1, "R6 shr64");
        send(SAR, 0, 0, 0, 64'h8000_0000_0000_0000, 64'd4, 0, 64'hF800_0000_0000_0000, "R6 sar64");
        send(SAR, 1, 0, 0, 64'hAAAA_AAAA_8000_0000, 64'd4, 0, 64'h0000_0000_F800_0000, "R6 sar32");
        // R7 sign-extending moves
        send(MSX, 0, 0, 0, 64'h0, 64'h80, 0, 64'hFFFF_FFFF_FFFF_FF80, "R7 sx8");
        send(MSX, 1, 1, 0, 64'h0, 64'h8001, 0, 64'h0000_0000_FFFF_8001, "R7 sx16 w32");
        send(MSX, 0, 2, 0, 64'h0, 64'h1234_5678_8000_0000, 0, 64'hFFFF_FFFF_8000_0000, "R7 sx32");
        send(MSX, 0, 3, 0, 64'h0, 64'h1234_5678_9ABC_DEF0, 0, 64'h1234_5678_9ABC_DEF0, "R7 sx64");
        // R8 unsigned divide and remainder
        send(DIV, 0, 0, 0, 64'd100, 64'd7, 0, 64'd14, "R8 div64");
        send(MOD, 0, 0, 0, 64'd100, 64'd7, 0, 64'd2, "R8 mod64");
        send(DIV, 1, 0, 0, 64'hFFFF_FFFF_0000_0010, 64'h5_0000_0003, 0, 64'd5, "R8 div32");
        send(MOD, 1, 0, 0, 64'hFFFF_FFFF_0000_0010, 64'h5_0000_0003, 0, 64'd1, "R8 mod32");
        send(DIV, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 0, 64'h7FFF_FFFF_FFFF_FFFF, "R8 div unsigned");
        // R9 zero divisor
        send(DIV, 0, 0, 0, 64'd123, 64'd0, 0, 64'd0, "R9 div by zero");
        send(DIV, 0, 0, 1, 64'd123, 64'd9, 32'd0, 64'd0, "R9 div by zero imm");
        send(MOD, 0, 0, 0, 64'd123, 64'd0, 0, 64'd123, "R9 mod by zero");
        send(MOD, 1, 0, 0, 64'hAB_0000_0042, 64'd0, 0, 64'h42, "R9 mod32 by zero");
        // R10 endian conversion, little-endian host
        send(TLE, 0, 1, 0, 64'h1122_3344_5566_7788, 0, 0, 64'h7788, "R10 tole16");
        send(TLE, 0, 3, 0, 64'h1122_3344_5566_7788, 0, 0, 64'h1122_3344_5566_7788, "R10 tole64");
        send(TBE, 0, 1, 0, 64'h1122_3344_5566_7788, 0, 0, 64'h8877, "R10 tobe16");
        send(TBE, 0, 2, 0, 64'h1122_3344_5566_7788, 0, 0, 64'h8877_6655, "R10 tobe32");
        send(TBE, 1, 3, 0, 64'h1122_3344_5566_7788, 0, 0, 64'h8877_6655_4433_2211, "R10 tobe64 w32 ignored");
        // R11 byte reversal
        send(BRV, 0, 2, 0, 64'h1122_3344_5566_7788, 0, 0, 64'h8877_6655, "R11 brev32");
        send(BRV, 0, 3, 0, 64'h1122_3344_5566_7788, 0, 0, 64'h8877_6655_4433_2211, "R11 brev64");
        send(BRV, 0, 0, 0, 64'h1122_3344_5566_7788, 0, 0, 64'h88, "R11 brev8");

        // R12: requests while busy are dropped
        send(DIV, 0, 0, 0, 64'd50, 64'd5, 0, 64'd10, "R12 div before poke");
        in_op = ADD; in_w32 = 0; in_use_imm = 0; in_dst = 64'd1; in_src = 64'd1;
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        send(ADD, 0, 0, 0, 64'd7, 64'd8, 0, 64'd15, "R12 after poke");

        for (int k = 0; k < 1000 && exp_q.size() != 0; k++) @(negedge clk);
        repeat (5) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R2: actual pending=%0d expected pending=0", exp_q.size());
        end
        finish_run();
    end

endmodule